// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a memory read port and an instruction decoder. It keeps a small byte FIFO topped up with code bytes read from memory at its own fetch pointer, so the decoder can take one byte per clock without waiting for the bus. The decoder pops bytes through a valid/pop handshake. When it needs to read an operand from memory, it raises a data request. That request wins the bus at the next point where a bus cycle may begin. On a taken branch, a flush input empties the queue and restarts fetching at the branch target.

Every bus cycle is a single 16-bit read that lasts a fixed number of clocks, four by default. A fetch from an even address yields two code bytes. A fetch from an odd address yields one byte, the upper half of the word, which brings the pointer back to an even address. Prefetching only starts when the queue will have at least two free slots. This leaves room for a whole word and never drops a returned byte.

Top module: `ifq_prefetch`

## Requirements
- R1: The queue holds at most six bytes and delivers them in first-in first-out order, so popped bytes always follow consecutive addresses starting from the reset address or the most recent flush target.
- R2: A prefetch bus cycle is started only when the queue, after the current clock's push and pop, has at least two free bytes. With six bytes held, or with five held, the bus stays idle until the decoder pops.
- R3: A fetch reads the 16-bit word at the even address formed by clearing bit 0 of the fetch pointer. At an even pointer the low byte (bits 7:0) is queued first, then the high byte (bits 15:8), and the pointer advances by 2. At an odd pointer only the high byte is queued and the pointer advances by 1.
- R4: A pending data request takes the bus ahead of prefetch at the next point where a bus cycle may start. A request raised during a fetch waits for that fetch to finish and then starts back to back with it. dack_o is high in the last clock of the data cycle, and ddata_o then carries the word at daddr_i with bit 0 cleared.
- R5: A flush discards every queued byte in the same clock, and the next bytes delivered come from the flush target address.
- R6: When a flush arrives while a fetch is in flight, the data that fetch returns is never queued.
- R7: Every bus cycle keeps mem_rd_o high for exactly four consecutive clocks, with mem_addr_o stable. A new cycle may begin in the clock right after one ends.
- R8: When the queue is empty, a fetched byte is offered on byte_o with byte_valid_o high during the last clock of its bus cycle, and it can be popped in that clock.
- R9: During reset the queue is empty and the bus is idle. The first clock after reset starts a fetch at the reset address (default 0xFFFF0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Control transfer: empty queue, restart fetching |
| flush_addr_i | input | ADDR_W | Restart address used with flush_i |
| pop_i | input | 1 | Decoder takes byte_o this clock |
| byte_valid_o | output | 1 | byte_o holds a queued byte |
| byte_o | output | 8 | Oldest queued byte |
| dreq_i | input | 1 | Operand read request, held until dack_o |
| daddr_i | input | ADDR_W | Operand address |
| dack_o | output | 1 | Operand word on ddata_o this clock |
| ddata_o | output | 16 | Operand word |
| mem_rd_o | output | 1 | Bus read cycle in progress |
| mem_addr_o | output | ADDR_W | Even word address of the current cycle |
| mem_rdata_i | input | 16 | Read data, sampled in the cycle's last clock |

## Verification
Two events can fall in the same clock. The first pair is a fetch completing into an empty queue while the decoder pops the very byte it returns. The bench provokes this by flushing while the bus is idle and popping in the fourth clock after the flush, then expects the target byte and a valid that was low for the three clocks before. The second pair is a fetch finishing while a data request is pending and the queue has room. The bench raises the request one clock into a fetch started by a flush, and expects the data address on the bus in the very next clock and dack_o eight clocks after the flush. Random traffic mixes pops, flushes at arbitrary bus phases and data requests, and compares every popped byte against a byte-address model of memory.

// File: rtl/ifq_prefetch.sv
module ifq_prefetch #(
  parameter int QDEPTH = 6,
  parameter int ADDR_W = 20,
  parameter int BUS_CLKS = 4,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 'hFFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              pop_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  input  logic              dreq_i,
  input  logic [ADDR_W-1:0] daddr_i,
  output logic              dack_o,
  output logic [15:0]       ddata_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [15:0]       mem_rdata_i
);
  localparam int PW = $clog2(QDEPTH);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int BW = $clog2(BUS_CLKS);

  function automatic logic [PW-1:0] adv(logic [PW-1:0] p, int k);
    int s;
    s = int'(p) + k;
    if (s >= QDEPTH) s = s - QDEPTH;
    return PW'(s);
  endfunction

  logic [7:0]        q [QDEPTH];
  logic [PW-1:0]     rd, wr;
  logic [CW-1:0]     cnt, cnt_n;
  logic [ADDR_W-1:0] fptr, fptr_n, baddr;
  logic              busy, bdata, bdrop;
  logic [BW-1:0]     bcnt;
  logic [1:0]        npush;
  logic [7:0]        b0;
  logic              popping, start_d, start_f;

  wire last  = busy && (bcnt == BW'(BUS_CLKS - 1));
  wire fdone = last && !bdata && !bdrop && !flush_i;

  assign npush        = fdone ? (baddr[0] ? 2'd1 : 2'd2) : 2'd0;
  assign b0           = baddr[0] ? mem_rdata_i[15:8] : mem_rdata_i[7:0];
  assign byte_valid_o = (cnt != '0) || (npush != 2'd0);
  assign byte_o       = (cnt != '0) ? q[rd] : b0;
  assign popping      = pop_i && byte_valid_o;
  assign cnt_n        = flush_i ? '0 : CW'(int'(cnt) + int'(npush) - int'(popping));
  assign fptr_n       = flush_i ? flush_addr_i : fptr + ADDR_W'(npush);
  assign dack_o       = last && bdata;
  assign ddata_o      = mem_rdata_i;
  assign start_d      = (!busy || last) && dreq_i && !dack_o;
  assign start_f      = (!busy || last) && !start_d && (int'(cnt_n) <= QDEPTH - 2);
  assign mem_rd_o     = busy;
  assign mem_addr_o   = {baddr[ADDR_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd <= '0; wr <= '0; cnt <= '0;
      fptr <= RESET_ADDR; baddr <= '0;
      busy <= 1'b0; bdata <= 1'b0; bdrop <= 1'b0; bcnt <= '0;
    end else begin
      if (npush != 2'd0) q[wr] <= b0;
      if (npush == 2'd2) q[adv(wr, 1)] <= mem_rdata_i[15:8];
      if (flush_i) begin
        rd <= '0; wr <= '0;
      end else begin
        rd <= adv(rd, int'(popping));
        wr <= adv(wr, int'(npush));
      end
      cnt  <= cnt_n;
      fptr <= fptr_n;
      if (start_d || start_f) begin
        busy  <= 1'b1;
        bcnt  <= '0;
        bdata <= start_d;
        bdrop <= 1'b0;
        baddr <= start_d ? daddr_i : fptr_n;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        bcnt <= bcnt + 1'b1;
        if (flush_i && !bdata) bdrop <= 1'b1;
      end
    end
  end

  assert_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= QDEPTH);
  assert_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bdata) |-> int'(cnt) <= QDEPTH - 2);
  assert_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !bdata && dreq_i) |=> (busy && bdata));
  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(baddr)));
endmodule

// File: tb/ifq_prefetch_tb.sv
module ifq_prefetch_tb;
  logic        clk = 0, rst_n = 0;
  logic        flush_i = 0, pop_i = 0, dreq_i = 0;
  logic [19:0] flush_addr_i = '0, daddr_i = '0;
  logic        byte_valid_o, dack_o, mem_rd_o;
  logic [7:0]  byte_o;
  logic [15:0] ddata_o, mem_rdata_i;
  logic [19:0] mem_addr_o;

  int checks = 0, failures = 0, acks = 0, cyc = 0;
  logic [19:0] exp_ptr = 20'hFFFF0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] membyte(logic [19:0] a);
    logic [31:0] t;
    t = {12'd0, a} * 32'd37;
    return t[9:2] ^ a[19:12];
  endfunction

  assign mem_rdata_i = {membyte(mem_addr_o + 20'd1), membyte(mem_addr_o)};

  ifq_prefetch u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .pop_i(pop_i), .byte_valid_o(byte_valid_o), .byte_o(byte_o),
    .dreq_i(dreq_i), .daddr_i(daddr_i), .dack_o(dack_o), .ddata_o(ddata_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(bit want_pop, bit do_flush, logic [19:0] tgt);
    @(negedge clk);
    cyc++;
    if (dack_o) begin
      chk(ddata_o == {membyte({daddr_i[19:1], 1'b1}), membyte({daddr_i[19:1], 1'b0})},
          "R4 data word", ddata_o, 0);
      dreq_i = 0;
      acks++;
    end
    pop_i = 0;
    if (want_pop && byte_valid_o) begin
      chk(byte_o == membyte(exp_ptr), "R1 byte order", byte_o, membyte(exp_ptr));
      exp_ptr++;
      pop_i = 1;
    end
    flush_i = do_flush;
    flush_addr_i = tgt;
    if (do_flush) exp_ptr = tgt;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n, hi, a0;
    bit seen;
    void'($urandom(32'd4711));
    repeat (4) begin
      @(negedge clk);
      chk(!mem_rd_o && !byte_valid_o, "R9 reset idle", {mem_rd_o, byte_valid_o}, 0);
    end
    rst_n = 1;
    step(0, 0, 0);
    chk(mem_rd_o && mem_addr_o == 20'hFFFF0, "R9 first fetch", mem_addr_o, 20'hFFFF0);

    repeat (40) step(0, 0, 0);
    chk(!mem_rd_o, "R2 full stall", mem_rd_o, 0);
    step(1, 0, 0);
    seen = 0;
    repeat (10) begin step(0, 0, 0); seen |= mem_rd_o; end
    chk(!seen, "R2 one free byte", seen, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    chk(mem_rd_o && mem_addr_o == 20'hFFFF6, "R2/R3 resume at +6", mem_addr_o, 20'hFFFF6);
    hi = 0;
    repeat (8) begin if (mem_rd_o) hi++; step(0, 0, 0); end
    chk(hi == 4, "R7 four clocks", hi, 4);
    repeat (12) step(1, 0, 0);
    chk(exp_ptr > 20'hFFFF9, "R1 drained bytes", exp_ptr, 20'hFFFFA);

    repeat (20) step(0, 0, 0);
    step(0, 1, 20'h00101);
    step(0, 0, 0);
    chk(mem_addr_o == 20'h00100, "R3 odd word address", mem_addr_o, 20'h00100);
    chk(!byte_valid_o, "R8 not yet valid", byte_valid_o, 0);
    step(0, 0, 0); chk(!byte_valid_o, "R8 not yet valid", byte_valid_o, 0);
    step(0, 0, 0); chk(!byte_valid_o, "R8 not yet valid", byte_valid_o, 0);
    step(1, 0, 0);
    chk(exp_ptr == 20'h00102, "R8 bypass pop", exp_ptr, 20'h00102);
    step(0, 0, 0);
    chk(mem_addr_o == 20'h00102, "R3 odd advance by 1", mem_addr_o, 20'h00102);

    repeat (20) step(0, 0, 0);
    step(0, 1, 20'h00200);
    step(0, 0, 0);
    dreq_i = 1; daddr_i = 20'h00345; a0 = acks;
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(0, 0, 0);
    chk(mem_addr_o == 20'h00344, "R4 priority after fetch", mem_addr_o, 20'h00344);
    step(0, 0, 0); step(0, 0, 0);
    chk(acks == a0, "R4 not early", acks, a0);
    step(0, 0, 0);
    chk(acks == a0 + 1, "R4 dack timing", acks, a0 + 1);

    repeat (20) step(0, 0, 0);
    dreq_i = 1; daddr_i = 20'h0ABCE; a0 = acks;
    repeat (3) step(0, 0, 0);
    chk(acks == a0, "R4 idle bus not early", acks, a0);
    step(0, 0, 0);
    chk(acks == a0 + 1, "R4 idle bus dack", acks, a0 + 1);

    repeat (20) step(1, 0, 0);
    n = 0;
    while (!mem_rd_o && n < 20) begin step(0, 0, 0); n++; end
    step(0, 1, 20'h00400);
    repeat (30) step(1, 0, 0);
    chk(exp_ptr > 20'h00408, "R6 restart after in-flight flush", exp_ptr, 20'h00409);

    for (int i = 0; i < 4000; i++) begin
      bit p, f;
      p = ($urandom % 10) < 6;
      f = ($urandom % 150) == 0;
      step(p, f, 20'($urandom));
      if (!dreq_i && ($urandom % 30) == 0) begin
        dreq_i = 1; daddr_i = 20'($urandom);
      end
    end
    n = 0;
    while (dreq_i && n < 20) begin step(0, 0, 0); n++; end
    chk(!dreq_i, "R4 last request served", dreq_i, 0);
    summary();
    $finish;
  end
endmodule